// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This block adds or subtracts two integer operands and produces a registered result together with four condition flags: negative, zero, overflow and carry. Besides ordinary two's-complement arithmetic it offers a tagged mode. Tagged mode serves language runtimes that store a small type tag in the lowest bits of each machine word. In that mode a nonzero tag on either operand is reported through the overflow flag, so software can catch a non-integer operand with the same test it uses for arithmetic overflow.

Every operation may either update the flag register or leave it as it was. This lets a scheduler move flag-neutral arithmetic freely between a flag-setting instruction and the branch that reads its flags. The sum or difference is always delivered on the result port, whether or not a tag error is reported. The operand width and the tag width are parameters. The default is a 32-bit datapath with a 2-bit tag.

Top module: `tagadd_unit`

## Requirements
- R1: One clock after the operands are presented, `result` holds `op_a + op_b` modulo 2^WIDTH when `op_sub` is 0, and `op_a - op_b` modulo 2^WIDTH when `op_sub` is 1.
- R2: When `cc_en` is 1, on the next clock `flag_n` takes bit WIDTH-1 of the new result, and `flag_z` is 1 exactly when the new result is all zeros.
- R3: When `cc_en` is 1, `flag_c` takes the unsigned carry out of an add. For a subtract it takes the borrow, which is 1 exactly when `op_a < op_b` as unsigned numbers.
- R4: When `cc_en` is 1 and `op_tagged` is 0, `flag_v` is 1 exactly when the operation overflows as signed two's-complement arithmetic.
- R5: When `cc_en` is 1 and `op_tagged` is 1, `flag_v` is the OR of signed overflow and a tag error. A tag error means that the low TAG_W bits (bits 1:0 by default) of `op_a` or of `op_b` are not all zero.
- R6: A tag error does not change `result`, `flag_n`, `flag_z` or `flag_c`. They hold the same values as for the untagged operation.
- R7: When `cc_en` is 0, all four flags keep their previous values on the next clock, while `result` still updates.
- R8: While `rst` is 1, on each clock `result` and all four flags are cleared to 0.
- R9: When `op_tagged` is 0, nonzero tag bits in the operands have no effect on `flag_v`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand (minuend for subtract) |
| op_b | input | WIDTH | Second operand (subtrahend for subtract) |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| op_tagged | input | 1 | 1 enables tag checking on both operands |
| cc_en | input | 1 | 1 lets this operation update the flags |
| result | output | WIDTH | Registered sum or difference |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow / tag-error flag |
| flag_c | output | 1 | Registered carry (add) or borrow (subtract) flag |

## Verification
The bound checker watches several behaviours on every cycle: reset clearing, flag hold while `cc_en` is low, negative and zero tracking the freshly written result, a forced overflow after a tagged operand with a nonzero tag, and the add and subtract results themselves. The carry and borrow values, the exact signed-overflow boundaries, and the absence of any tag effect in untagged mode are shown only by the bench. It sweeps every operand pair of a 6-bit build in all four mode combinations and compares each output against arithmetic computed independently in the bench. A reset applied in the middle of the sweep, after the flags have been set, is also covered only by the bench scenarios.

// File: rtl/tagadd_pkg.sv
package tagadd_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } tagadd_flags_t;

  localparam tagadd_flags_t TAGADD_FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};
endpackage

// File: rtl/tagadd_arith.sv
module tagadd_arith #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry_flag,
  output logic             signed_ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum   = wide[WIDTH-1:0];
    // for subtract the raw carry is the inverse of the borrow
    carry_flag = sub ? ~wide[WIDTH] : wide[WIDTH];
    signed_ovf = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
  end
endmodule

// File: rtl/tagadd_tagchk.sv
module tagadd_tagchk #(
  parameter int TAG_W = 2
) (
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  input  logic             enable,
  output logic             tag_err
);
  logic [TAG_W-1:0] merged;

  genvar gi;
  generate
    for (gi = 0; gi < TAG_W; gi++) begin : g_bit
      assign merged[gi] = tag_a[gi] | tag_b[gi];
    end
  endgenerate

  assign tag_err = enable & (|merged);
endmodule

// File: rtl/tagadd_flagreg.sv
module tagadd_flagreg
  import tagadd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  tagadd_flags_t next_flags,
  output tagadd_flags_t flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= TAGADD_FLAGS_CLEAR;
    end else if (load) begin
      flags <= next_flags;
    end
  end
endmodule

// File: rtl/tagadd_unit.sv
module tagadd_unit
  import tagadd_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             op_sub,
  input  logic             op_tagged,
  input  logic             cc_en,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum;
  logic             carry_flag;
  logic             signed_ovf;
  logic             tag_err;
  tagadd_flags_t    next_flags;
  tagadd_flags_t    flags_q;

  tagadd_arith #(.WIDTH(WIDTH)) u_arith (
    .a          (op_a),
    .b          (op_b),
    .sub        (op_sub),
    .sum        (sum),
    .carry_flag (carry_flag),
    .signed_ovf (signed_ovf)
  );

  tagadd_tagchk #(.TAG_W(TAG_W)) u_tagchk (
    .tag_a   (op_a[TAG_W-1:0]),
    .tag_b   (op_b[TAG_W-1:0]),
    .enable  (op_tagged),
    .tag_err (tag_err)
  );

  always_comb begin
    next_flags.n = sum[MSB];
    next_flags.z = (sum == '0);
    next_flags.v = signed_ovf | tag_err;
    next_flags.c = carry_flag;
  end

  tagadd_flagreg u_flagreg (
    .clk        (clk),
    .rst        (rst),
    .load       (cc_en),
    .next_flags (next_flags),
    .flags      (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else begin
      result <= sum;
    end
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;
endmodule

// File: rtl/tagadd_checker.sv
module tagadd_checker #(
  parameter int WIDTH = 32,
  parameter int TAG_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             op_sub,
  input logic             op_tagged,
  input logic             cc_en,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c
);
  assert_add_result_R1: assert property (@(posedge clk) disable iff (rst)
    !op_sub |=> result == WIDTH'($past(op_a) + $past(op_b)));

  assert_sub_result_R1: assert property (@(posedge clk) disable iff (rst)
    op_sub |=> result == WIDTH'($past(op_a) - $past(op_b)));

  assert_neg_flag_R2: assert property (@(posedge clk) disable iff (rst)
    cc_en |=> flag_n == result[WIDTH-1]);

  assert_zero_flag_R2: assert property (@(posedge clk) disable iff (rst)
    cc_en |=> flag_z == (result == '0));

  assert_tag_error_R5: assert property (@(posedge clk) disable iff (rst)
    (cc_en && op_tagged && ((op_a[TAG_W-1:0] != '0) || (op_b[TAG_W-1:0] != '0))) |=> flag_v);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cc_en |=> $stable({flag_n, flag_z, flag_v, flag_c}));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (result == '0) && !flag_n && !flag_z && !flag_v && !flag_c);
endmodule

bind tagadd_unit tagadd_checker #(.WIDTH(WIDTH), .TAG_W(TAG_W)) u_tagadd_checker (
  .clk       (clk),
  .rst       (rst),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_sub    (op_sub),
  .op_tagged (op_tagged),
  .cc_en     (cc_en),
  .result    (result),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_c    (flag_c)
);

// File: tb/tagadd_unit_tb.sv
module tagadd_unit_tb;
  localparam int W  = 6;
  localparam int TW = 2;
  localparam int N  = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         op_sub = 1'b0;
  logic         op_tagged = 1'b0;
  logic         cc_en = 1'b0;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit en, ez, ev, ec;

  always #10 clk = ~clk;

  tagadd_unit #(.WIDTH(W), .TAG_W(TW)) u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
    .op_tagged(op_tagged), .cc_en(cc_en), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit sub,
                       input bit tg, input bit ce);
    int  raw;
    int  r;
    bit  c, v, terr, ovf, sa, sb, sr;
    string vreq;
    op_a = W'(a); op_b = W'(b); op_sub = sub; op_tagged = tg; cc_en = ce;
    @(negedge clk);
    if (sub) begin
      raw = a - b;
      c   = (a < b);
    end else begin
      raw = a + b;
      c   = raw >= N;
    end
    r  = raw & (N - 1);
    sa = a[W-1]; sb = b[W-1]; sr = r[W-1];
    ovf  = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    terr = ((a | b) & ((1 << TW) - 1)) != 0;
    v    = ovf | (tg & terr);
    chk(result == W'(r), (tg && terr) ? "R6" : "R1", "result", result, r);
    if (ce) begin
      en = r[W-1]; ez = (r == 0); ev = v; ec = c;
    end
    chk(flag_n == en, ce ? "R2" : "R7", "flag_n", flag_n, en);
    chk(flag_z == ez, ce ? "R2" : "R7", "flag_z", flag_z, ez);
    chk(flag_c == ec, ce ? ((tg && terr) ? "R6" : "R3") : "R7", "flag_c", flag_c, ec);
    if (!ce)            vreq = "R7";
    else if (tg)        vreq = "R5";
    else if (terr)      vreq = "R9";
    else                vreq = "R4";
    chk(flag_v == ev, vreq, "flag_v", flag_v, ev);
  endtask

  task automatic check_reset_state();
    chk(result == '0, "R8", "result", result, 0);
    chk({flag_n, flag_z, flag_v, flag_c} == 4'b0000, "R8", "flags",
        {flag_n, flag_z, flag_v, flag_c}, 0);
    en = 0; ez = 0; ev = 0; ec = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    // directed corners
    apply(31, 1, 1'b0, 1'b0, 1'b1);   // R4 positive overflow
    apply(0, 1, 1'b1, 1'b0, 1'b1);    // R3 borrow
    apply(4, 4, 1'b1, 1'b1, 1'b1);    // R5 zero result, clean tags
    apply(5, 4, 1'b0, 1'b1, 1'b1);    // R5 tag error
    apply(3, 0, 1'b0, 1'b0, 1'b0);    // R7 flags held
    apply(1, 2, 1'b0, 1'b0, 1'b1);    // R9 untagged, nonzero tags
    // full sweep over every operand pair and mode
    for (int mode = 0; mode < 4; mode++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          apply(a, b, mode[0], mode[1], ((a + 3 * b + mode) % 5) != 0);
        end
      end
      if (mode == 1) begin
        // R8 reset in the middle of the run, after flags have been set
        apply(31, 1, 1'b0, 1'b0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule